// File: doc/BRIEF.md
# Logarithmic Gain Setting Register Interface

This block is the digital control front end of a processor-programmed logarithmic gain/attenuation stage. A host writes a gain setting over a parallel bus using an active-low chip select, an active-low write strobe and one address line. The block stores the setting, decodes its coarse and fine codes into one-hot select vectors for two resistor ladders, and drives a powerdown control and a gain/attenuation direction flag. It also drives a signed gain value in tenths of a decibel, which a system can use for checking.

The write strobe is brought into the system clock domain through a two-flop synchroniser. The chip select, address and data lines travel through the same two stages, so all of them are sampled together. A write takes effect on the rising (trailing) edge of the strobe, and only when chip select is low at that point. A parameter selects one of two bus variants. The eight-bit variant splits the setting across two addressed registers and adds a powerdown bit. The nine-bit variant loads the whole setting in one write and has no powerdown.

Top module: `loggain_ctrl`

## Requirements
- R1: After asynchronous reset: coarse_sel = 16'h0001, fine_sel = 16'h0001, atten_sel = 0, pwr_down = 0 and gain_tenth_db = 0.
- R2: A write strobe edge that arrives while bus_cs_n is high changes no stored field and no output.
- R3: Eight-bit variant, bus_addr = 0: the write loads bus_data[8] as the attenuate flag, bus_data[7:4] as the coarse code and bus_data[3:1] as fine code bits 3..1. Fine bit 0 and powerdown keep their values.
- R4: Eight-bit variant, bus_addr = 1: the write loads bus_data[1] as fine code bit 0 and bus_data[2] as the powerdown bit. The attenuate flag, coarse code and fine bits 3..1 keep their values.
- R5: While the stored powerdown bit is 1, pwr_down is 1 and the stored gain setting, its select vectors and gain_tenth_db are retained. Clearing the bit brings pwr_down back to 0.
- R6: coarse_sel has exactly the bit at the coarse code's index set, and fine_sel has exactly the bit at the fine code's index set.
- R7: gain_tenth_db equals 15*coarse + fine when the attenuate flag is 0, and the negative of that value when it is 1. It stays within -240..+240. A zero code gives 0 for either flag value.
- R8: The select vectors and atten_sel change two clock edges after the clock edge that first samples the strobe high. gain_tenth_db follows one clock edge later.
- R9: Nine-bit variant: one write loads bus_data[8] as the attenuate flag, bus_data[7:4] as coarse and bus_data[3:0] as fine, whatever bus_addr is. pwr_down stays 0.
- R10: The value stored is the data present when the strobe rises, not the data present when it fell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr_n | input | 1 | Write strobe, active low, asynchronous to clk |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_addr | input | 1 | Register select (eight-bit variant only) |
| bus_data | input | 9 | Data lines; bit 0 is used only by the nine-bit variant |
| coarse_sel | output | 16 | One-hot coarse ladder switch select |
| fine_sel | output | 16 | One-hot fine ladder switch select |
| atten_sel | output | 1 | 1 = attenuation, 0 = gain |
| pwr_down | output | 1 | Powerdown request for the analog section |
| gain_tenth_db | output | 9 | Signed gain setting in 0.1 dB units |

## Verification
A corrupted coarse or fine field shows up right away as a shifted bit in the matching select vector. One clock later it shows up as a wrong gain_tenth_db value. A flipped attenuate flag flips the sign of the gain value, except at a zero code. A lost or spurious commit, for example a write accepted with chip select high or a powerdown that disturbs the setting, is caught at the next readback of all five outputs, a few cycles after the strobe rises.

// File: rtl/loggain_pkg.sv
package loggain_pkg;
    localparam int CODE_W      = 4;
    localparam int SEL_W       = 1 << CODE_W;
    localparam int DATA_W      = 2 * CODE_W + 1;
    localparam int GAIN_W      = 9;
    localparam int COARSE_STEP = 15;

    typedef struct packed {
        logic              atten;
        logic [CODE_W-1:0] coarse;
        logic [CODE_W-1:0] fine;
        logic              pdn;
    } setting_t;

    typedef struct packed {
        logic              wr_n;
        logic              cs_n;
        logic              addr;
        logic [DATA_W-1:0] data;
    } bus_smp_t;
endpackage

// File: rtl/loggain_bus_sync.sv
module loggain_bus_sync
    import loggain_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              cs_n,
    input  logic              addr,
    input  logic [DATA_W-1:0] data,
    output logic              commit,
    output logic              commit_addr,
    output logic [DATA_W-1:0] commit_data
);
    typedef struct packed {
        bus_smp_t s1;
        bus_smp_t s2;
        logic     prev_wr_n;
    } sync_t;

    localparam bus_smp_t IDLE = '{wr_n: 1'b1, cs_n: 1'b1, addr: 1'b0, data: '0};

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d           = sync_q;
        sync_d.s1        = '{wr_n: wr_n, cs_n: cs_n, addr: addr, data: data};
        sync_d.s2        = sync_q.s1;
        sync_d.prev_wr_n = sync_q.s2.wr_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '{s1: IDLE, s2: IDLE, prev_wr_n: 1'b1};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign commit      = sync_q.s2.wr_n & ~sync_q.prev_wr_n & ~sync_q.s2.cs_n;
    assign commit_addr = sync_q.s2.addr;
    assign commit_data = sync_q.s2.data;
endmodule

// File: rtl/loggain_onehot_dec.sv
module loggain_onehot_dec #(
    parameter int CODE_W = 4,
    parameter int OUT_W  = 1 << CODE_W
) (
    input  logic [CODE_W-1:0] code,
    output logic [OUT_W-1:0]  sel
);
    for (genvar i = 0; i < OUT_W; i++) begin : g_line
        assign sel[i] = (code == CODE_W'(i));
    end
endmodule

// File: rtl/loggain_db_calc.sv
module loggain_db_calc
    import loggain_pkg::*;
(
    input  logic                     atten,
    input  logic [CODE_W-1:0]        coarse,
    input  logic [CODE_W-1:0]        fine,
    output logic signed [GAIN_W-1:0] gain
);
    logic [GAIN_W-1:0] mag;

    always_comb begin
        mag  = GAIN_W'(coarse) * GAIN_W'(COARSE_STEP) + GAIN_W'(fine);
        gain = atten ? -$signed(mag) : $signed(mag);
    end
endmodule

// File: rtl/loggain_ctrl.sv
module loggain_ctrl
    import loggain_pkg::*;
#(
    parameter bit NINE_BIT = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr_n,
    input  logic                     bus_cs_n,
    input  logic                     bus_addr,
    input  logic [DATA_W-1:0]        bus_data,
    output logic [SEL_W-1:0]         coarse_sel,
    output logic [SEL_W-1:0]         fine_sel,
    output logic                     atten_sel,
    output logic                     pwr_down,
    output logic signed [GAIN_W-1:0] gain_tenth_db
);
    typedef struct packed {
        setting_t                  set;
        logic signed [GAIN_W-1:0]  gain;
    } state_t;

    state_t                   state_d, state_q;
    setting_t                 wr_next;
    logic                     wr_commit;
    logic                     wr_addr;
    logic [DATA_W-1:0]        wr_data;
    logic signed [GAIN_W-1:0] gain_calc;

    loggain_bus_sync u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_n        (bus_wr_n),
        .cs_n        (bus_cs_n),
        .addr        (bus_addr),
        .data        (bus_data),
        .commit      (wr_commit),
        .commit_addr (wr_addr),
        .commit_data (wr_data)
    );

    // Parameter picks the register layout of a write.
    if (NINE_BIT) begin : g_nine
        always_comb begin
            wr_next        = state_q.set;
            wr_next.atten  = wr_data[2*CODE_W];
            wr_next.coarse = wr_data[2*CODE_W-1:CODE_W];
            wr_next.fine   = wr_data[CODE_W-1:0];
            wr_next.pdn    = 1'b0;
        end
    end else begin : g_eight
        always_comb begin
            wr_next = state_q.set;
            if (!wr_addr) begin
                wr_next.atten               = wr_data[2*CODE_W];
                wr_next.coarse              = wr_data[2*CODE_W-1:CODE_W];
                wr_next.fine[CODE_W-1:1]    = wr_data[CODE_W-1:1];
            end else begin
                wr_next.fine[0]             = wr_data[1];
                wr_next.pdn                 = wr_data[2];
            end
        end
    end

    loggain_db_calc u_calc (
        .atten  (state_q.set.atten),
        .coarse (state_q.set.coarse),
        .fine   (state_q.set.fine),
        .gain   (gain_calc)
    );

    always_comb begin
        state_d      = state_q;
        state_d.gain = gain_calc;
        if (wr_commit) begin
            state_d.set = wr_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    loggain_onehot_dec #(.CODE_W(CODE_W)) u_coarse_dec (
        .code (state_q.set.coarse),
        .sel  (coarse_sel)
    );

    loggain_onehot_dec #(.CODE_W(CODE_W)) u_fine_dec (
        .code (state_q.set.fine),
        .sel  (fine_sel)
    );

    assign atten_sel     = state_q.set.atten;
    assign pwr_down      = state_q.set.pdn;
    assign gain_tenth_db = state_q.gain;
endmodule

// File: rtl/loggain_ctrl_chk.sv
module loggain_ctrl_chk
    import loggain_pkg::*;
#(
    parameter bit NINE_BIT = 1'b0
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     commit,
    input setting_t                 stored,
    input logic [SEL_W-1:0]         coarse_sel,
    input logic [SEL_W-1:0]         fine_sel,
    input logic                     atten_sel,
    input logic                     pwr_down,
    input logic signed [GAIN_W-1:0] gain_tenth_db
);
    assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(coarse_sel) == 1) && ($countones(fine_sel) == 1));

    assert_hold_without_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(stored));

    assert_gain_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((gain_tenth_db < 0) ==
                  ($past(atten_sel) && (($past(coarse_sel) != SEL_W'(1)) || ($past(fine_sel) != SEL_W'(1))))));

    assert_gain_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_tenth_db <= 240) && (gain_tenth_db >= -240));

    assert_no_pdn_nine_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(NINE_BIT && pwr_down));
endmodule

bind loggain_ctrl loggain_ctrl_chk #(.NINE_BIT(NINE_BIT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .commit        (wr_commit),
    .stored        (state_q.set),
    .coarse_sel    (coarse_sel),
    .fine_sel      (fine_sel),
    .atten_sel     (atten_sel),
    .pwr_down      (pwr_down),
    .gain_tenth_db (gain_tenth_db)
);

// File: tb/loggain_ctrl_tb.sv
module loggain_ctrl_tb;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_n = 1'b1;
    logic        cs8_n = 1'b1;
    logic        cs9_n = 1'b1;
    logic        addr = 1'b0;
    logic [8:0]  data = '0;

    logic [15:0] c8, f8, c9, f9;
    logic        a8, p8, a9, p9;
    logic signed [8:0] g8, g9;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model of the eight-bit instance
    int m_a = 0, m_c = 0, m_f = 0, m_p = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    loggain_ctrl #(.NINE_BIT(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_n(wr_n), .bus_cs_n(cs8_n), .bus_addr(addr),
        .bus_data(data), .coarse_sel(c8), .fine_sel(f8), .atten_sel(a8),
        .pwr_down(p8), .gain_tenth_db(g8));

    loggain_ctrl #(.NINE_BIT(1'b1)) u_dut9 (
        .clk(clk), .rst_n(rst_n), .bus_wr_n(wr_n), .bus_cs_n(cs9_n), .bus_addr(addr),
        .bus_data(data), .coarse_sel(c9), .fine_sel(f9), .atten_sel(a9),
        .pwr_down(p9), .gain_tenth_db(g9));

    function automatic int exp_gain(int a, int c, int f);
        return a ? -(15 * c + f) : (15 * c + f);
    endfunction

    function automatic logic [8:0] pk_hi(int a, int c, int f31);
        return {a[0], c[3:0], f31[2:0], 1'b0};
    endfunction

    function automatic logic [8:0] pk_lo(int p, int f0);
        return {6'b0, p[0], f0[0], 1'b0};
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk8(string tag);
        chk({tag, " coarse_sel"}, c8, 64'd1 << m_c);
        chk({tag, " fine_sel"}, f8, 64'd1 << m_f);
        chk({tag, " atten_sel"}, a8, m_a);
        chk({tag, " pwr_down"}, p8, m_p);
        chk({tag, " gain"}, g8, exp_gain(m_a, m_c, m_f));
    endtask

    task automatic bus_write(bit to9, bit cs_high, bit a0, logic [8:0] d);
        @(negedge clk);
        if (to9) cs9_n = cs_high; else cs8_n = cs_high;
        addr = a0;
        data = d;
        wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (6) @(negedge clk);
        cs8_n = 1'b1;
        cs9_n = 1'b1;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk8("R1 reset eight-bit");
        chk("R1 reset nine-bit coarse", c9, 1);
        chk("R1 reset nine-bit fine", f9, 1);
        chk("R1 reset nine-bit gain", g9, 0);
        chk("R1 reset nine-bit pdn", p9, 0);
    endtask

    task automatic t_high_reg;
        bus_write(0, 0, 0, pk_hi(0, 5, 3'b101));
        m_a = 0; m_c = 5; m_f = 10;
        chk8("R3 R6 R7 high register write");
    endtask

    task automatic t_low_reg;
        bus_write(0, 0, 1, pk_lo(0, 1));
        m_f = 11;
        chk8("R4 low register fine bit");
    endtask

    task automatic t_powerdown;
        bus_write(0, 0, 1, pk_lo(1, 1));
        m_p = 1;
        chk8("R5 powerdown retains setting");
        bus_write(0, 0, 1, pk_lo(0, 1));
        m_p = 0;
        chk8("R5 powerdown cleared");
    endtask

    task automatic t_cs_high;
        bus_write(0, 1, 0, 9'h1FF);
        chk8("R2 cs high write ignored");
        bus_write(0, 1, 1, 9'h1FF);
        chk8("R2 cs high low-register write ignored");
    endtask

    task automatic t_full_atten;
        bus_write(0, 0, 0, pk_hi(1, 15, 3'b111));
        m_a = 1; m_c = 15; m_f = 15;
        chk8("R7 R6 full attenuation -240");
        bus_write(0, 0, 0, pk_hi(0, 15, 3'b111));
        m_a = 0;
        chk8("R7 full gain +240");
    endtask

    task automatic t_zero_atten;
        bus_write(0, 0, 0, pk_hi(1, 0, 0));
        bus_write(0, 0, 1, pk_lo(0, 0));
        m_a = 1; m_c = 0; m_f = 0;
        chk8("R7 zero code attenuate gives 0");
    endtask

    task automatic t_rise_capture;
        @(negedge clk);
        cs8_n = 1'b0; addr = 1'b0; data = pk_hi(0, 2, 3'b000); wr_n = 1'b0;
        repeat (3) @(negedge clk);
        data = pk_hi(0, 9, 3'b001);
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (6) @(negedge clk);
        cs8_n = 1'b1;
        m_a = 0; m_c = 9; m_f = 2;
        chk8("R10 data at rising strobe stored");
    endtask

    task automatic t_latency;
        int old_g;
        old_g = exp_gain(m_a, m_c, m_f);
        @(negedge clk);
        cs8_n = 1'b0; addr = 1'b0; data = pk_hi(0, 1, 3'b000); wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        m_c = 1; m_f = 0;
        chk("R8 selects updated", c8, 16'h0002);
        chk("R8 gain still old", g8, old_g);
        @(negedge clk);
        chk("R8 gain one cycle later", g8, exp_gain(m_a, m_c, m_f));
        repeat (4) @(negedge clk);
        cs8_n = 1'b1;
    endtask

    task automatic t_nine_bit;
        bus_write(1, 0, 0, {1'b0, 4'd3, 4'd4});
        chk("R9 nine-bit coarse", c9, 16'h0008);
        chk("R9 nine-bit fine", f9, 16'h0010);
        chk("R9 nine-bit gain", g9, 49);
        bus_write(1, 0, 1, {1'b1, 4'd8, 4'd0});
        chk("R9 nine-bit addr ignored gain", g9, -120);
        chk("R9 nine-bit atten", a9, 1);
        chk("R9 nine-bit no powerdown", p9, 0);
        chk8("R2 eight-bit untouched by other select");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_high_reg();
        t_low_reg();
        t_powerdown();
        t_cs_high();
        t_full_atten();
        t_zero_atten();
        t_rise_capture();
        t_latency();
        t_nine_bit();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule